// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block keeps the reservation state a processor needs to implement load-exclusive / store-exclusive pairs. It holds one reserved cache-line address and a one-bit state, open or exclusive. A local load-exclusive reserves its line. The matching store-exclusive then receives a pass or fail status in the same cycle it is presented.

The reservation is dropped when any of these happens:
- a local store-exclusive is presented;
- a local clear-exclusive is presented;
- another agent stores to the reserved line;
- the reserved line is evicted.

Local and remote monitoring are merged into one state machine. That state machine works at cache-line granularity, so any access anywhere inside the reserved line counts as the same line. Stores from other agents arrive on a snoop port. Evictions arrive on a notification port.

The block sits beside the load/store pipeline. The pipeline takes `stex_status_o` as the value returned by the store-exclusive. It uses `stex_wen_o` to gate the actual memory write.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is open (`excl_o` = 0), the reserved line reads 0, and with no request `stex_status_o` and `stex_wen_o` are 0.
- R2: A load-exclusive with no conflicting clear in the same cycle makes `excl_o` 1 from the next cycle. `resv_line_o` then holds the address with its low log2(LINE_BYTES) bits dropped (address >> 6 for 64-byte lines).
- R3: A store-exclusive whose line equals the reserved line while exclusive passes. In the same cycle, `stex_status_o` is 0 and `stex_wen_o` is 1.
- R4: Any other store-exclusive fails. In the same cycle, `stex_status_o` is 1 and `stex_wen_o` is 0.
- R5: Every store-exclusive, whether it passes or fails, leaves the monitor open in the next cycle, unless a load-exclusive to a different line arrives in the same cycle.
- R6: A snooped store to the reserved line clears the monitor. A snooped store to any other line leaves state and reserved line unchanged.
- R7: An eviction of the reserved line clears the monitor. An eviction of any other line has no effect.
- R8: A clear-exclusive opens the monitor in the next cycle, even when a load-exclusive arrives in the same cycle.
- R9: A load-exclusive while already exclusive replaces the reserved line. A store-exclusive to the old line then fails.
- R10: When a load-exclusive and a store-exclusive, snoop or eviction arrive in the same cycle, the load-exclusive wins only if the clearing address lies in a different line from the load-exclusive. Otherwise the monitor ends open.
- R11: Only a load-exclusive moves the monitor from open to exclusive. Snoops, evictions, store-exclusives and clear-exclusives never do.
- R12: Address bits below the line size are ignored in every comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ldex_valid_i | input | 1 | Local load-exclusive |
| ldex_addr_i | input | ADDR_W | Load-exclusive address |
| stex_valid_i | input | 1 | Local store-exclusive |
| stex_addr_i | input | ADDR_W | Store-exclusive address |
| clrex_i | input | 1 | Local clear-exclusive |
| snoop_valid_i | input | 1 | Store observed from another agent |
| snoop_addr_i | input | ADDR_W | Snooped store address |
| evict_valid_i | input | 1 | Line eviction notification |
| evict_addr_i | input | ADDR_W | Evicted line address |
| stex_status_o | output | 1 | Store-exclusive result: 0 pass, 1 fail; 0 when idle |
| stex_wen_o | output | 1 | Write enable for a passing store-exclusive |
| excl_o | output | 1 | Monitor state: 1 exclusive, 0 open |
| resv_line_o | output | ADDR_W-log2(LINE_BYTES) | Reserved line address |

## Verification
A wrong state bit or a corrupted reserved line is not visible when it happens. It shows up only when the next store-exclusive returns the wrong status and write enable, in the same cycle as that store. `excl_o` and `resv_line_o` expose the fault one cycle after the event that caused it.

For that reason, every scenario follows each state change with a store-exclusive probe. The probes use addresses that differ from the reserved line only in offset bits, and addresses one line away. The same-cycle conflict cases are run both with the clearing address in the load-exclusive's line and with it outside that line.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic {MON_OPEN = 1'b0, MON_EXCL = 1'b1} mon_state_e;
  // clearing sources compared against the reservation and the incoming load-exclusive
  localparam int unsigned N_SRC     = 3;
  localparam int unsigned SRC_STEX  = 0;
  localparam int unsigned SRC_SNOOP = 1;
  localparam int unsigned SRC_EVICT = 2;
endpackage

// File: rtl/excl_line_match.sv
module excl_line_match #(
  parameter int unsigned LINE_W = 26
) (
  input  logic [LINE_W-1:0] a_i,
  input  logic [LINE_W-1:0] b_i,
  output logic              eq_o
);
  assign eq_o = (a_i == b_i);
endmodule

// File: rtl/excl_mon_fsm.sv
module excl_mon_fsm
  import excl_mon_pkg::*;
#(
  parameter int unsigned LINE_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldex_valid_i,
  input  logic [LINE_W-1:0] ld_line_i,
  input  logic              clrex_i,
  input  logic [N_SRC-1:0]  src_valid_i,
  input  logic [N_SRC-1:0]  hit_resv_i,
  input  logic [N_SRC-1:0]  hit_ld_i,
  output logic              excl_o,
  output logic [LINE_W-1:0] line_o
);
  mon_state_e        state_q, state_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              remote_hit;

  assign remote_hit = hit_resv_i[SRC_SNOOP] | hit_resv_i[SRC_EVICT];

  always_comb begin
    state_d = state_q;
    line_d  = line_q;
    if (ldex_valid_i) begin
      line_d  = ld_line_i;
      // clear on the same line (or a global clear) beats the new reservation
      state_d = (clrex_i || (|hit_ld_i)) ? MON_OPEN : MON_EXCL;
    end else if (clrex_i || src_valid_i[SRC_STEX] || remote_hit) begin
      state_d = MON_OPEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_OPEN;
      line_q  <= '0;
    end else begin
      state_q <= state_d;
      line_q  <= line_d;
    end
  end

  assign excl_o = (state_q == MON_EXCL);
  assign line_o = line_q;

  // R11
  only_ldex_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(excl_o) |-> $past(ldex_valid_i));
  // R5
  stex_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i[SRC_STEX] && !ldex_valid_i) |=> !excl_o);
  // R8
  clrex_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clrex_i |=> !excl_o);
  // R6
  remote_hit_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ldex_valid_i && remote_hit) |=> !excl_o);
  // R9
  ldex_loads_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldex_valid_i |=> (line_o == $past(ld_line_i)));
  // R10
  same_line_conflict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldex_valid_i && (|hit_ld_i)) |=> !excl_o);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ldex_valid_i,
  input  logic [ADDR_W-1:0] ldex_addr_i,
  input  logic              stex_valid_i,
  input  logic [ADDR_W-1:0] stex_addr_i,
  input  logic              clrex_i,
  input  logic              snoop_valid_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  input  logic              evict_valid_i,
  input  logic [ADDR_W-1:0] evict_addr_i,
  output logic              stex_status_o,
  output logic              stex_wen_o,
  output logic              excl_o,
  output logic [LINE_W-1:0] resv_line_o
);
  logic [LINE_W-1:0] ld_line;
  logic [LINE_W-1:0] src_line [N_SRC];
  logic [N_SRC-1:0]  src_valid, match_resv, match_ld, hit_resv, hit_ld;
  logic              stex_pass;

  assign ld_line               = ldex_addr_i[ADDR_W-1:OFF_W];
  assign src_line[SRC_STEX]    = stex_addr_i[ADDR_W-1:OFF_W];
  assign src_line[SRC_SNOOP]   = snoop_addr_i[ADDR_W-1:OFF_W];
  assign src_line[SRC_EVICT]   = evict_addr_i[ADDR_W-1:OFF_W];
  assign src_valid[SRC_STEX]   = stex_valid_i;
  assign src_valid[SRC_SNOOP]  = snoop_valid_i;
  assign src_valid[SRC_EVICT]  = evict_valid_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    excl_line_match #(.LINE_W(LINE_W)) u_vs_resv (
      .a_i (src_line[g]),
      .b_i (resv_line_o),
      .eq_o(match_resv[g])
    );
    excl_line_match #(.LINE_W(LINE_W)) u_vs_ld (
      .a_i (src_line[g]),
      .b_i (ld_line),
      .eq_o(match_ld[g])
    );
  end

  assign hit_resv = src_valid & match_resv;
  assign hit_ld   = src_valid & match_ld;

  excl_mon_fsm #(.LINE_W(LINE_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ldex_valid_i(ldex_valid_i),
    .ld_line_i   (ld_line),
    .clrex_i     (clrex_i),
    .src_valid_i (src_valid),
    .hit_resv_i  (hit_resv),
    .hit_ld_i    (hit_ld),
    .excl_o      (excl_o),
    .line_o      (resv_line_o)
  );

  assign stex_pass     = excl_o & hit_resv[SRC_STEX];
  assign stex_wen_o    = stex_pass;
  assign stex_status_o = stex_valid_i & ~stex_pass;

  // R4
  fail_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stex_valid_i && !excl_o) |-> (stex_status_o && !stex_wen_o));
  // R3
  wen_needs_stex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stex_wen_o |-> (stex_valid_i && !stex_status_o));
endmodule

// File: tb/tb_excl_monitor.sv
module tb_excl_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ldv = 0, stv = 0, clr = 0, snv = 0, evv = 0;
  logic [ADDR_W-1:0] lda = '0, sta = '0, sna = '0, eva = '0;
  logic stex_status, stex_wen, excl;
  logic [LINE_W-1:0] resv_line;
  logic got_status, got_wen;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ldex_valid_i(ldv), .ldex_addr_i(lda),
    .stex_valid_i(stv), .stex_addr_i(sta),
    .clrex_i(clr),
    .snoop_valid_i(snv), .snoop_addr_i(sna),
    .evict_valid_i(evv), .evict_addr_i(eva),
    .stex_status_o(stex_status), .stex_wen_o(stex_wen),
    .excl_o(excl), .resv_line_o(resv_line)
  );

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one cycle of events; status/wen sampled before the edge
  task automatic fire(input logic l, input logic [31:0] la, input logic s, input logic [31:0] sa,
                      input logic c, input logic n, input logic [31:0] na,
                      input logic e, input logic [31:0] ea);
    ldv = l; lda = la; stv = s; sta = sa; clr = c; snv = n; sna = na; evv = e; eva = ea;
    #1;
    got_status = stex_status; got_wen = stex_wen;
    @(posedge clk); #1;
    ldv = 0; stv = 0; clr = 0; snv = 0; evv = 0;
  endtask

  task automatic ldex(input logic [31:0] a);  fire(1, a, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic stex(input logic [31:0] a);  fire(0, 0, 1, a, 0, 0, 0, 0, 0); endtask
  task automatic snoop(input logic [31:0] a); fire(0, 0, 0, 0, 0, 1, a, 0, 0); endtask
  task automatic evict(input logic [31:0] a); fire(0, 0, 0, 0, 0, 0, 0, 1, a); endtask

  task automatic t_reset();
    chk(excl, 0, "R1 state after reset");
    chk(resv_line, 0, "R1 line after reset");
    chk({stex_status, stex_wen}, 0, "R1 idle status");
    stex(32'h0);
    chk({got_status, got_wen}, 2'b10, "R4 stex after reset fails");
    chk(excl, 0, "R11 stex does not set");
  endtask

  task automatic t_pass();
    ldex(32'h1000);
    chk(excl, 1, "R2 ldex sets");
    chk(resv_line, 32'h1000 >> 6, "R2 reserved line");
    stex(32'h1024);
    chk({got_status, got_wen}, 2'b01, "R3 R12 pass with offset difference");
    chk(excl, 0, "R5 open after pass");
    stex(32'h1000);
    chk({got_status, got_wen}, 2'b10, "R5 second stex fails");
  endtask

  task automatic t_fail_line();
    ldex(32'h2000);
    stex(32'h2040);
    chk({got_status, got_wen}, 2'b10, "R4 other line fails");
    chk(excl, 0, "R5 open after fail");
  endtask

  task automatic t_snoop();
    ldex(32'h3000);
    snoop(32'h3100);
    chk(excl, 1, "R6 snoop other line ignored");
    chk(resv_line, 32'h3000 >> 6, "R6 line kept");
    snoop(32'h303C);
    chk(excl, 0, "R6 R12 snoop same line clears");
    stex(32'h3000);
    chk({got_status, got_wen}, 2'b10, "R6 stex after snoop fails");
  endtask

  task automatic t_evict();
    ldex(32'h4000);
    evict(32'h3FC0);
    chk(excl, 1, "R7 evict other line ignored");
    stex(32'h4008);
    chk({got_status, got_wen}, 2'b01, "R7 reservation survives");
    ldex(32'h4000);
    evict(32'h4030);
    chk(excl, 0, "R7 evict same line clears");
  endtask

  task automatic t_clrex();
    ldex(32'h5000);
    fire(0, 0, 0, 0, 1, 0, 0, 0, 0);
    chk(excl, 0, "R8 clrex clears");
    fire(1, 32'h5000, 0, 0, 1, 0, 0, 0, 0);
    chk(excl, 0, "R8 clrex beats ldex");
  endtask

  task automatic t_replace();
    ldex(32'h6000);
    ldex(32'h7000);
    chk(resv_line, 32'h7000 >> 6, "R9 line replaced");
    chk(excl, 1, "R9 still exclusive");
    stex(32'h6000);
    chk({got_status, got_wen}, 2'b10, "R9 old line fails");
  endtask

  task automatic t_conflict();
    fire(1, 32'h8000, 0, 0, 0, 1, 32'h8010, 0, 0);
    chk(excl, 0, "R10 same-line snoop beats ldex");
    fire(1, 32'h8000, 0, 0, 0, 1, 32'h9000, 0, 0);
    chk(excl, 1, "R10 other-line snoop loses");
    fire(1, 32'hA000, 0, 0, 0, 0, 0, 1, 32'h8000);
    chk(excl, 1, "R10 evict of old line loses to new ldex");
    chk(resv_line, 32'hA000 >> 6, "R10 new line reserved");
    fire(1, 32'hA000, 1, 32'hA020, 0, 0, 0, 0, 0);
    chk({got_status, got_wen}, 2'b01, "R10 stex uses current state");
    chk(excl, 0, "R10 same-line stex beats ldex");
    fire(1, 32'hB000, 1, 32'hC000, 0, 0, 0, 0, 0);
    chk(excl, 1, "R5 R10 other-line stex loses to ldex");
  endtask

  task automatic t_only_ldex();
    fire(0, 0, 0, 0, 1, 0, 0, 0, 0);
    snoop(32'h0); evict(32'h0); stex(32'h0);
    fire(0, 0, 1, 32'h40, 1, 1, 32'h80, 1, 32'hC0);
    chk(excl, 0, "R11 no set without ldex");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_pass();
    t_fail_line();
    t_snoop();
    t_evict();
    t_clrex();
    t_replace();
    t_conflict();
    t_only_ldex();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule